// File: doc/BRIEF.md
# Pad Wakeup Event Detector

This block watches chip pads while the rest of the system sleeps and raises a wake request when a configured pad activity is seen. It holds a number of independent detector channels. Each channel picks one pad through its own select field, can route that pad through a debounce stage, and checks the resulting level against one of five event kinds: a rising edge, a falling edge, any edge, a high level held long enough, or a low level held long enough. A hit sets a sticky cause bit for that channel.

The wake request is the OR of all cause bits. Software learns which channel woke the system by reading the cause vector and acknowledges it by a cause write that carries a clear mask. Configuration fields (enable, debounce enable, event kind, hold threshold, pad select) are plain inputs, driven by a register block outside this one; the block runs on a single clock with a synchronous active-high reset.

Top module: `wkup_detect_top`

## Requirements
- R1: After reset every cause bit and the wake request are 0.
- R2: Event kind 0 sets the channel's cause bit on a rising edge of its level; with debounce off, a pad rise sampled at clock edge n shows on the cause output after edge n+1.
- R3: Event kind 1 sets the cause bit on a falling edge of the level, and a rising edge leaves it clear.
- R4: Event kind 2 sets the cause bit on either edge of the level.
- R5: Event kind 3 sets the cause bit in the cycle in which the level has been 1 for T+1 consecutive cycles, T being the channel's threshold (a threshold of 0 acts as 1); a shorter high pulse sets nothing.
- R6: Event kind 4 does the same for a level held at 0 for T+1 consecutive cycles.
- R7: The hold counter restarts on every level change and saturates at full scale, so one long pulse fires only once; a cause bit cleared during that pulse stays clear.
- R8: A channel whose enable is 0, or whose event kind field holds 5, 6 or 7, never sets its cause bit.
- R9: With debounce on, the level takes a new pad value only after 4 consecutive equal samples; a pulse of 3 samples or fewer is not seen.
- R10: Cause bits are sticky; a cause write clears exactly the bits whose mask bit is 1 and keeps the others.
- R11: In a cycle with a cause write, no cause bit is set, even with a mask of 0; an event in that cycle is lost.
- R12: The wake request is 1 when any cause bit is 1 and 0 when all are 0.
- R13: Each channel watches the pad whose index equals its select field (bits 3c+2..3c for channel c with 8 pads), and no other pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_i | input | NUM_PADS | Pad input levels |
| det_en_i | input | NUM_DET | Channel enable, one bit per channel |
| det_filt_i | input | NUM_DET | Debounce enable, one bit per channel |
| det_mode_i | input | 3*NUM_DET | Event kind, 3 bits per channel (0 rise, 1 fall, 2 any edge, 3 held high, 4 held low) |
| det_thr_i | input | CNT_W*NUM_DET | Hold threshold per channel |
| det_sel_i | input | clog2(NUM_PADS)*NUM_DET | Pad select per channel |
| cause_wr_i | input | 1 | Cause write strobe |
| cause_clr_i | input | NUM_DET | Clear mask carried by the cause write |
| cause_o | output | NUM_DET | Sticky cause bits |
| wake_req_o | output | 1 | Wake request, OR of cause bits |

## Verification
On every cycle the assertions watch the cause register rules (no set during a write, masked bits cleared, unmasked bits held), that disabled or reserved-kind channels never hit, that a held-level hit is not repeated in the next cycle, that a rising-kind hit follows a real rise, and that the debounced level only moves after matching samples. Whether a hit comes at the right threshold count, whether a short glitch is really swallowed by the debounce, and which pad a select value reaches can only be shown by the bench's scenarios, with a behavioural reference model compared against the cause and wake outputs each cycle.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    // Event kinds; field values 5..7 are reserved and never hit.
    typedef enum logic [2:0] {
        WK_RISE    = 3'd0,
        WK_FALL    = 3'd1,
        WK_EITHER  = 3'd2,
        WK_HELD_HI = 3'd3,
        WK_HELD_LO = 3'd4
    } wk_mode_e;

    // Per-channel static configuration gathered from the flat ports.
    typedef struct packed {
        logic       en;
        logic       filt;
        logic [2:0] mode;
    } wk_cfg_t;

    // Observations made on the channel level in one cycle.
    typedef struct packed {
        logic rise;
        logic fall;
        logic held;
    } wk_obs_t;

    function automatic logic wk_event(logic [2:0] mode, logic lv, wk_obs_t o);
        logic r;
        case (mode)
            WK_RISE:    r = o.rise;
            WK_FALL:    r = o.fall;
            WK_EITHER:  r = o.rise | o.fall;
            WK_HELD_HI: r = o.held & lv;
            WK_HELD_LO: r = o.held & ~lv;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wkup_pad_filter.sv
module wkup_pad_filter #(
    parameter int NUM_PADS = 8,
    parameter int SEL_W    = 3,
    parameter int FILT_CYC = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PADS-1:0] pad_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                filt_en_i,
    output logic                lv_o
);

    logic pick;
    logic raw_q;
    logic deb;

    assign pick = pad_i[sel_i];

    always_ff @(posedge clk) begin
        if (rst) raw_q <= 1'b0;
        else     raw_q <= pick;
    end

    generate
        if (FILT_CYC >= 2) begin : g_deb
            logic [FILT_CYC-1:0] hist_q;
            logic [FILT_CYC-1:0] hist_d;
            logic                deb_q;
            logic                deb_d;

            assign hist_d = {hist_q[FILT_CYC-2:0], pick};

            always_comb begin
                if (&hist_d)       deb_d = 1'b1;
                else if (~|hist_d) deb_d = 1'b0;
                else               deb_d = deb_q;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                    deb_q  <= 1'b0;
                end else begin
                    hist_q <= hist_d;
                    deb_q  <= deb_d;
                end
            end

            assign deb = deb_q;

            // R9
            deb_settle_chk: assert property (@(posedge clk) disable iff (rst)
                (deb_q != $past(deb_q)) |-> (($past(pick) == deb_q) && ($past(pick, 2) == deb_q)));
        end else begin : g_nodeb
            assign deb = raw_q;
        end
    endgenerate

    assign lv_o = filt_en_i ? deb : raw_q;

endmodule

// File: rtl/wkup_event.sv
module wkup_event #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lv_i,
    input  logic             en_i,
    input  logic [2:0]       mode_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             hit_o
);
    import wkup_pkg::*;

    localparam int                RUN_W   = CNT_W + 1;
    localparam logic [RUN_W-1:0]  RUN_MAX = '1;
    localparam logic [RUN_W-1:0]  RUN_ONE = RUN_W'(1);

    logic             prev_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_d;
    logic [RUN_W-1:0] eff;
    logic             steady;
    wk_obs_t          obs;

    assign eff    = (thr_i == '0) ? RUN_ONE : {1'b0, thr_i};
    assign steady = (lv_i == prev_q);

    always_comb begin
        if (!steady)              run_d = RUN_ONE;
        else if (run_q != RUN_MAX) run_d = run_q + RUN_ONE;
        else                      run_d = run_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            run_q  <= '0;
        end else begin
            prev_q <= lv_i;
            run_q  <= run_d;
        end
    end

    assign obs.rise = lv_i & ~prev_q;
    assign obs.fall = ~lv_i & prev_q;
    assign obs.held = steady && (run_q == eff);

    assign hit_o = en_i & wk_event(mode_i, lv_i, obs);

    // R7
    held_once_chk: assert property (@(posedge clk) disable iff (rst)
        obs.held |=> (!obs.held || !$stable(thr_i)));

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i || (mode_i > 3'd4)) |-> !hit_o);

    // R2
    rise_real_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_o && (mode_i == WK_RISE)) |-> (lv_i && !$past(lv_i)));

endmodule

// File: rtl/wkup_cause.sv
module wkup_cause #(
    parameter int NUM_DET = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_DET-1:0] hit_i,
    input  logic               wr_i,
    input  logic [NUM_DET-1:0] clr_i,
    output logic [NUM_DET-1:0] cause_o,
    output logic               wake_o
);

    logic [NUM_DET-1:0] cause_q;

    always_ff @(posedge clk) begin
        if (rst)       cause_q <= '0;
        else if (wr_i) cause_q <= cause_q & ~clr_i;
        else           cause_q <= cause_q | hit_i;
    end

    assign cause_o = cause_q;
    assign wake_o  = |cause_q;

    // R10
    clr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> ((cause_o & $past(clr_i)) == '0));

    // R11
    wr_noset_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> ((cause_o & ~$past(cause_o)) == '0));

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> (($past(cause_o) & ~cause_o) == '0));

    // R12
    wake_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_o) |-> ($past(|hit_i) && !$past(wr_i)));

endmodule

// File: rtl/wkup_detect_top.sv
module wkup_detect_top #(
    parameter int NUM_PADS = 8,
    parameter int NUM_DET  = 4,
    parameter int CNT_W    = 8,
    parameter int FILT_CYC = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_PADS-1:0]                 pad_i,
    input  logic [NUM_DET-1:0]                  det_en_i,
    input  logic [NUM_DET-1:0]                  det_filt_i,
    input  logic [NUM_DET*3-1:0]                det_mode_i,
    input  logic [NUM_DET*CNT_W-1:0]            det_thr_i,
    input  logic [NUM_DET*$clog2(NUM_PADS)-1:0] det_sel_i,
    input  logic                                cause_wr_i,
    input  logic [NUM_DET-1:0]                  cause_clr_i,
    output logic [NUM_DET-1:0]                  cause_o,
    output logic                                wake_req_o
);
    import wkup_pkg::*;

    localparam int SEL_W = $clog2(NUM_PADS);

    wk_cfg_t            cfg [NUM_DET];
    logic [NUM_DET-1:0] lv;
    logic [NUM_DET-1:0] hit;

    generate
        for (genvar c = 0; c < NUM_DET; c++) begin : g_ch
            assign cfg[c].en   = det_en_i[c];
            assign cfg[c].filt = det_filt_i[c];
            assign cfg[c].mode = det_mode_i[c*3 +: 3];

            wkup_pad_filter #(
                .NUM_PADS (NUM_PADS),
                .SEL_W    (SEL_W),
                .FILT_CYC (FILT_CYC)
            ) u_filt (
                .clk       (clk),
                .rst       (rst),
                .pad_i     (pad_i),
                .sel_i     (det_sel_i[c*SEL_W +: SEL_W]),
                .filt_en_i (cfg[c].filt),
                .lv_o      (lv[c])
            );

            wkup_event #(
                .CNT_W (CNT_W)
            ) u_evt (
                .clk    (clk),
                .rst    (rst),
                .lv_i   (lv[c]),
                .en_i   (cfg[c].en),
                .mode_i (cfg[c].mode),
                .thr_i  (det_thr_i[c*CNT_W +: CNT_W]),
                .hit_o  (hit[c])
            );
        end
    endgenerate

    wkup_cause #(
        .NUM_DET (NUM_DET)
    ) u_cause (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (hit),
        .wr_i    (cause_wr_i),
        .clr_i   (cause_clr_i),
        .cause_o (cause_o),
        .wake_o  (wake_req_o)
    );

    // R1
    rst_clean_chk: assert property (@(posedge clk)
        $past(rst) |-> (cause_o == '0 && !wake_req_o));

endmodule

// File: tb/wkup_detect_top_bench.sv
module wkup_detect_top_bench;

    localparam int NP = 8;
    localparam int ND = 4;
    localparam int CW = 8;
    localparam int FC = 4;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pad = '0;
    logic [ND-1:0] en = '0;
    logic [ND-1:0] filt = '0;
    logic [ND*3-1:0]  mode = '0;
    logic [ND*CW-1:0] thr = '0;
    logic [ND*SW-1:0] psel = '0;
    logic          wr = 1'b0;
    logic [ND-1:0] clr = '0;
    logic [ND-1:0] cause;
    logic          wake;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    wkup_detect_top #(.NUM_PADS(NP), .NUM_DET(ND), .CNT_W(CW), .FILT_CYC(FC)) u_wkup_detect_top (
        .clk(clk), .rst(rst), .pad_i(pad), .det_en_i(en), .det_filt_i(filt),
        .det_mode_i(mode), .det_thr_i(thr), .det_sel_i(psel),
        .cause_wr_i(wr), .cause_clr_i(clr), .cause_o(cause), .wake_req_o(wake));

    // Behavioural reference model
    bit          m_unf [ND];
    bit          m_filt[ND];
    bit          m_last[ND];
    int          m_srun[ND];
    bit          m_prev[ND];
    int          m_run [ND];
    bit [ND-1:0] m_cause;

    always @(posedge clk) begin
        bit          lv;
        bit          fire;
        bit          s;
        int          run;
        int          eff;
        bit [ND-1:0] hits;
        if (rst) begin
            for (int d = 0; d < ND; d++) begin
                m_unf[d] = 0; m_filt[d] = 0; m_last[d] = 0; m_srun[d] = FC;
                m_prev[d] = 0; m_run[d] = 0;
            end
            m_cause = '0;
        end else begin
            hits = '0;
            for (int d = 0; d < ND; d++) begin
                lv  = filt[d] ? m_filt[d] : m_unf[d];
                run = (lv == m_prev[d]) ? m_run[d] + 1 : 1;
                eff = (thr[d*CW +: CW] == 0) ? 1 : int'(thr[d*CW +: CW]);
                case (mode[d*3 +: 3])
                    3'd0: fire = lv && !m_prev[d];
                    3'd1: fire = !lv && m_prev[d];
                    3'd2: fire = lv != m_prev[d];
                    3'd3: fire = lv && (run == eff + 1);
                    3'd4: fire = !lv && (run == eff + 1);
                    default: fire = 0;
                endcase
                if (en[d]) hits[d] = fire;
                m_prev[d] = lv;
                m_run[d]  = run;
                s = pad[psel[d*SW +: SW]];
                if (s == m_last[d]) m_srun[d]++;
                else                m_srun[d] = 1;
                m_last[d] = s;
                m_unf[d]  = s;
                if (m_srun[d] >= FC) m_filt[d] = s;
            end
            if (wr) m_cause = m_cause & ~clr;
            else    m_cause = m_cause | hits;
        end
    end

    // Compare against the model on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_chk++;
            if (cause !== m_cause || wake !== (|m_cause)) begin
                n_fail++;
                $display("FAIL %s model cycle %0d: cause=%b wake=%b expected cause=%b wake=%b",
                         cur_req, cyc, cause, wake, m_cause, |m_cause);
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: cycle=%0d expected finish before 20000", cyc);
            report();
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(logic got, logic exp, string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic cfg_ch(int d, bit e, bit f, logic [2:0] m, logic [CW-1:0] t, logic [SW-1:0] sel);
        en[d] = e;
        filt[d] = f;
        mode[d*3 +: 3] = m;
        thr[d*CW +: CW] = t;
        psel[d*SW +: SW] = sel;
    endtask

    task automatic clear(logic [ND-1:0] mask);
        wr = 1'b1;
        clr = mask;
        tick(1);
        wr = 1'b0;
        clr = '0;
    endtask

    initial begin
        for (int d = 0; d < ND; d++) cfg_ch(d, 0, 0, 3'd0, 8'd1, SW'(d));
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1: reset state
        cur_req = "R1";
        chk(wake, 1'b0, "R1 wake");
        for (int d = 0; d < ND; d++) chk(cause[d], 1'b0, "R1 cause");

        // R2: rising edge with exact latency, R12 wake follows
        cur_req = "R2";
        cfg_ch(0, 1, 0, 3'd0, 8'd1, 3'd0);
        tick(3);
        clear('1);
        pad[0] = 1'b1;
        tick(1);
        chk(cause[0], 1'b0, "R2 one edge after rise");
        tick(1);
        chk(cause[0], 1'b1, "R2 two edges after rise");
        chk(wake, 1'b1, "R12 wake set");
        cur_req = "R10";
        clear(4'b0001);
        chk(cause[0], 1'b0, "R10 cleared");
        chk(wake, 1'b0, "R12 wake low");

        // R3: falling edge only
        cur_req = "R3";
        cfg_ch(1, 1, 0, 3'd1, 8'd1, 3'd1);
        pad[1] = 1'b1;
        tick(4);
        chk(cause[1], 1'b0, "R3 rise ignored");
        pad[1] = 1'b0;
        tick(3);
        chk(cause[1], 1'b1, "R3 fall");

        // R4: either edge
        cur_req = "R4";
        cfg_ch(2, 1, 0, 3'd2, 8'd1, 3'd2);
        tick(2);
        clear('1);
        pad[2] = 1'b1;
        tick(3);
        chk(cause[2], 1'b1, "R4 rise");
        clear(4'b0100);
        pad[2] = 1'b0;
        tick(3);
        chk(cause[2], 1'b1, "R4 fall");

        // R5: held high against threshold 5
        cur_req = "R5";
        cfg_ch(3, 1, 0, 3'd3, 8'd5, 3'd3);
        tick(2);
        clear('1);
        pad[3] = 1'b1;
        tick(5);
        pad[3] = 1'b0;
        tick(4);
        chk(cause[3], 1'b0, "R5 five cycles high");
        pad[3] = 1'b1;
        tick(6);
        pad[3] = 1'b0;
        tick(4);
        chk(cause[3], 1'b1, "R5 six cycles high");

        // R6: held low against threshold 3
        cur_req = "R6";
        cfg_ch(3, 1, 0, 3'd4, 8'd3, 3'd3);
        pad[3] = 1'b1;
        tick(5);
        clear('1);
        pad[3] = 1'b0;
        tick(3);
        pad[3] = 1'b1;
        tick(4);
        chk(cause[3], 1'b0, "R6 three cycles low");
        pad[3] = 1'b0;
        tick(4);
        pad[3] = 1'b1;
        tick(3);
        chk(cause[3], 1'b1, "R6 four cycles low");

        // R7: one long pulse fires once
        cur_req = "R7";
        pad[0] = 1'b0;
        cfg_ch(0, 1, 0, 3'd3, 8'd2, 3'd0);
        tick(2);
        clear('1);
        pad[0] = 1'b1;
        tick(5);
        chk(cause[0], 1'b1, "R7 first hit");
        clear(4'b0001);
        tick(20);
        chk(cause[0], 1'b0, "R7 no second hit");
        pad[0] = 1'b0;

        // R8: disabled channel and reserved kinds
        cur_req = "R8";
        cfg_ch(1, 0, 0, 3'd2, 8'd1, 3'd1);
        tick(2);
        clear('1);
        pad[1] = 1'b1; tick(3); pad[1] = 1'b0; tick(3);
        chk(cause[1], 1'b0, "R8 disabled");
        for (int m = 5; m < 8; m++) begin
            cfg_ch(1, 1, 0, 3'(m), 8'd1, 3'd1);
            pad[1] = 1'b1; tick(4); pad[1] = 1'b0; tick(4);
            chk(cause[1], 1'b0, "R8 reserved kind");
        end

        // R9: debounce swallows 3-sample glitch, passes 4
        cur_req = "R9";
        cfg_ch(2, 1, 1, 3'd2, 8'd1, 3'd2);
        tick(6);
        clear('1);
        pad[2] = 1'b1; tick(3); pad[2] = 1'b0;
        tick(8);
        chk(cause[2], 1'b0, "R9 glitch ignored");
        pad[2] = 1'b1; tick(4); pad[2] = 1'b0;
        tick(8);
        chk(cause[2], 1'b1, "R9 stable pulse seen");

        // R11: write in the hit cycle drops the event
        cur_req = "R11";
        cfg_ch(0, 1, 0, 3'd0, 8'd1, 3'd0);
        tick(3);
        clear('1);
        pad[0] = 1'b1;
        tick(1);
        wr = 1'b1; clr = '0;
        tick(1);
        wr = 1'b0;
        chk(cause[0], 1'b0, "R11 event lost");
        tick(2);
        chk(cause[0], 1'b0, "R11 stays clear");

        // R13: pad select
        cur_req = "R13";
        pad[3] = 1'b0;
        cfg_ch(3, 1, 0, 3'd0, 8'd1, 3'd6);
        tick(3);
        clear('1);
        pad[3] = 1'b1;
        tick(3);
        chk(cause[3], 1'b0, "R13 unselected pad");
        pad[6] = 1'b1;
        tick(3);
        chk(cause[3], 1'b1, "R13 selected pad");

        // R10: partial clear keeps other bits
        cur_req = "R10";
        pad[0] = 1'b0; tick(2); pad[0] = 1'b1; tick(3);
        chk(cause[0], 1'b1, "R10 bit0 set");
        clear(4'b1000);
        chk(cause[3], 1'b0, "R10 masked bit cleared");
        chk(cause[0], 1'b1, "R10 unmasked bit kept");
        chk(wake, 1'b1, "R12 wake with one bit");

        tick(2);
        report();
    end

endmodule